// File: doc/BRIEF.md
# Chip sequence playback trigger controller

This block paces the replay of a chip sequence that another unit has already stored in memory. Every pulse of a chip-rate enable moves a read address one step forward. When the address reaches a programmable last address it returns to zero, and a marker then flags the new repetition. One of four trigger modes decides whether playback runs freely, waits for a first trigger, or restarts on each accepted trigger.

Trigger events come from two sources:
- an asynchronous external input, which is synchronized and then edge-detected on a selectable polarity;
- a single-cycle manual strobe from the host.

The block handles both sources the same way. An accepted trigger restarts playback at address zero, either at once or after a programmable number of chip periods. After a restart, further triggers are refused for a programmable inhibit window, also counted in chips. Every accepted trigger produces a one-cycle pulse on an output. Changing the mode, or raising the arm request, returns the block to the start state of the current mode.

Top module: `chip_play_trig`

## Requirements
- R1: While running, each clock with `chip_en_i` high advances `addr_o` by one. When `addr_o >= seq_last_i`, it returns to 0 instead.
- R2: `marker_o` goes high on the step that returns the address from the last address to 0. It stays high until the next chip step. It never goes high on a trigger restart or on a mode restart.
- R3: In mode 0 (auto), external edges and manual strobes have no effect: `trig_o` stays low and the address keeps counting.
- R4: In mode 1 (retrigger), playback runs after reset or after a mode restart. An accepted trigger restarts it at address 0.
- R5: In mode 2 (armed auto), `run_o` is low and `addr_o` is held at 0 until the first accepted trigger. After that, playback runs and every later trigger is ignored.
- R6: In mode 3 (armed retrigger), the block waits like mode 2 for the first trigger. After that, every accepted trigger restarts playback, as in mode 1.
- R7: `fall_sel_i`=0 selects the rising edge of `trig_i` and 1 selects the falling edge. A change of `trig_i` sampled at clock k gives `trig_o` high after clock k+2. A `man_trig_i` high sampled at clock m gives `trig_o` high after clock m.
- R8: The delay value is sampled when the trigger is accepted.
  - With `delay_i`=0, `run_o` is high with `addr_o`=0 in the cycle after acceptance.
  - With `delay_i`=D>0, `run_o` is low and `addr_o` is 0 until the D-th chip step after acceptance. At that step, `run_o` rises with `addr_o` still 0.
- R9: After a restart, triggers are ignored until `inhibit_i` chip steps have occurred while running. Triggers that arrive during the delay are also ignored.
- R10: `trig_o` is a one-cycle pulse for each accepted trigger and is low in every other cycle.
- R11: A change of `mode_i`, or `arm_i` high, returns the block to the start state of the new mode. That state is running at address 0 for modes 0 and 1, and waiting at address 0 for modes 2 and 3. No trigger is accepted in that cycle.
- R12: After reset, the block is in mode 0 and running, with `addr_o`=0 and `marker_o`=0 and `trig_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_i | input | 1 | Chip-rate step enable |
| mode_i | input | 2 | Trigger mode: 0 auto, 1 retrigger, 2 armed auto, 3 armed retrigger |
| arm_i | input | 1 | Return to the mode's start state |
| fall_sel_i | input | 1 | External edge polarity: 0 rising, 1 falling |
| trig_i | input | 1 | Asynchronous external trigger |
| man_trig_i | input | 1 | Manual trigger strobe |
| seq_last_i | input | ADDR_W | Last address of the sequence |
| delay_i | input | CNT_W | Start delay in chips |
| inhibit_i | input | CNT_W | Retrigger inhibit window in chips |
| addr_o | output | ADDR_W | Sequence memory read address |
| run_o | output | 1 | Playback running |
| marker_o | output | 1 | Wrap marker |
| trig_o | output | 1 | Accepted trigger pulse |

## Verification
Directed sequences exercise each mode in turn:
- counting through a wrap in auto mode, which separates a correct wrap compare from an off-by-one;
- a delayed restart followed by triggers inside and just after the inhibit window, which locates the exact chip step where acceptance reopens;
- rising and falling external edges, which pin down the synchronizer latency and the polarity select.

Random phases then mix all four modes with sparse or dense chip enables, short sequence lengths, small delays and windows, and toggling inputs. These phases reach combinations the directed cases miss, such as a trigger in the same cycle as a delay expiry or an arm request during an inhibit window.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO       = 2'd0,
    MODE_RETRIG     = 2'd1,
    MODE_ARM_AUTO   = 2'd2,
    MODE_ARM_RETRIG = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } state_e;
endpackage

// File: rtl/cpt_trig_in.sv
module cpt_trig_in #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic fall_sel_i,
  input  logic man_i,
  output logic evt_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  // sh[SYNC_STAGES-1] is the synchronized level, sh[SYNC_STAGES] its previous value
  logic [SH_W-1:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[SH_W-2:0], trig_i};
  end

  logic lvl, prv, edge_det;
  assign lvl      = sh[SYNC_STAGES-1];
  assign prv      = sh[SYNC_STAGES];
  assign edge_det = fall_sel_i ? (prv & ~lvl) : (lvl & ~prv);
  assign evt_o    = edge_det | man_i;
endmodule

// File: rtl/cpt_ctrl.sv
module cpt_ctrl
  import cpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chip_en_i,
  input  logic [1:0]       mode_i,
  input  logic             arm_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] inhibit_i,
  output logic             run_o,
  output logic             addr_clr_o,
  output logic             trig_o
);
  mode_e            mode_q;
  state_e           st_q;
  logic [CNT_W-1:0] dcnt_q, icnt_q;
  logic             chg, can_acc, acc;

  assign chg     = (mode_e'(mode_i) != mode_q) | arm_i;
  // bit 0 of the mode selects retrigger behaviour once running
  assign can_acc = (st_q == ST_WAIT) |
                   ((st_q == ST_RUN) & mode_q[0] & (icnt_q == '0));
  assign acc     = ~chg & evt_i & can_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_AUTO;
      st_q   <= ST_RUN;
      dcnt_q <= '0;
      icnt_q <= '0;
      trig_o <= 1'b0;
    end else begin
      trig_o <= acc;
      if (chg) begin
        mode_q <= mode_e'(mode_i);
        st_q   <= mode_i[1] ? ST_WAIT : ST_RUN;
        dcnt_q <= '0;
        icnt_q <= '0;
      end else if (acc) begin
        if (delay_i == '0) begin
          st_q   <= ST_RUN;
          icnt_q <= inhibit_i;
        end else begin
          st_q   <= ST_DELAY;
          dcnt_q <= delay_i;
        end
      end else if (chip_en_i) begin
        unique case (st_q)
          ST_DELAY: begin
            if (dcnt_q == CNT_W'(1)) begin
              st_q   <= ST_RUN;
              icnt_q <= inhibit_i;
            end
            dcnt_q <= dcnt_q - CNT_W'(1);
          end
          ST_RUN:  if (icnt_q != '0) icnt_q <= icnt_q - CNT_W'(1);
          default: ;
        endcase
      end
    end
  end

  assign run_o      = (st_q == ST_RUN);
  assign addr_clr_o = chg | acc | (st_q == ST_DELAY);
endmodule

// File: rtl/cpt_addr.sv
module cpt_addr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_i,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              marker_o
);
  logic at_end;
  assign at_end = (addr_o >= last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      marker_o <= 1'b0;
    end else if (clr_i) begin
      addr_o   <= '0;
      marker_o <= 1'b0;
    end else if (run_i && chip_en_i) begin
      marker_o <= at_end;
      addr_o   <= at_end ? '0 : addr_o + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/chip_play_trig.sv
module chip_play_trig #(
  parameter int ADDR_W      = 10,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_i,
  input  logic [1:0]        mode_i,
  input  logic              arm_i,
  input  logic              fall_sel_i,
  input  logic              trig_i,
  input  logic              man_trig_i,
  input  logic [ADDR_W-1:0] seq_last_i,
  input  logic [CNT_W-1:0]  delay_i,
  input  logic [CNT_W-1:0]  inhibit_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              run_o,
  output logic              marker_o,
  output logic              trig_o
);
  logic evt, addr_clr;

  cpt_trig_in #(.SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .fall_sel_i (fall_sel_i),
    .man_i      (man_trig_i),
    .evt_o      (evt)
  );

  cpt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chip_en_i  (chip_en_i),
    .mode_i     (mode_i),
    .arm_i      (arm_i),
    .evt_i      (evt),
    .delay_i    (delay_i),
    .inhibit_i  (inhibit_i),
    .run_o      (run_o),
    .addr_clr_o (addr_clr),
    .trig_o     (trig_o)
  );

  cpt_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chip_en_i (chip_en_i),
    .run_i     (run_o),
    .clr_i     (addr_clr),
    .last_i    (seq_last_i),
    .addr_o    (addr_o),
    .marker_o  (marker_o)
  );
endmodule

// File: rtl/cpt_chk.sv
module cpt_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chip_en_i,
  input logic [1:0]        mode_i,
  input logic [ADDR_W-1:0] seq_last_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              run_o,
  input logic              marker_o,
  input logic              trig_o,
  input logic              addr_clr
);
  // R1
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && chip_en_i && !addr_clr) |=>
      (addr_o == (($past(addr_o) >= $past(seq_last_i)) ? '0 : $past(addr_o) + ADDR_W'(1))));

  // R2
  marker_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    marker_o |-> (addr_o == '0));

  // R3
  auto_no_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'd0) |-> !trig_o);

  // R8
  idle_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> (addr_o == '0));

  // R10
  trig_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (addr_o == '0));
endmodule

bind chip_play_trig cpt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chip_en_i  (chip_en_i),
  .mode_i     (mode_i),
  .seq_last_i (seq_last_i),
  .addr_o     (addr_o),
  .run_o      (run_o),
  .marker_o   (marker_o),
  .trig_o     (trig_o),
  .addr_clr   (addr_clr)
);

// File: tb/chip_play_trig_test.sv
`timescale 1ns/1ps
module chip_play_trig_test;
  localparam int AW = 10;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          chip_en_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          arm_i = 1'b0;
  logic          fall_sel_i = 1'b0;
  logic          trig_i = 1'b0;
  logic          man_trig_i = 1'b0;
  logic [AW-1:0] seq_last_i = AW'(4);
  logic [CW-1:0] delay_i = '0;
  logic [CW-1:0] inhibit_i = '0;
  logic [AW-1:0] addr_o;
  logic          run_o, marker_o, trig_o;

  chip_play_trig #(.ADDR_W(AW), .CNT_W(CW)) uut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, derived from the requirements
  bit [1:0] m_mode;
  int       m_st;          // 0 waiting, 1 delaying, 2 running
  int       m_d, m_i, m_addr;
  bit       m_mark, m_trig, m_s1, m_s2, m_pv;

  function automatic bit edge_evt(bit fall, bit lvl, bit prv, bit man);
    return (fall ? (prv & ~lvl) : (lvl & ~prv)) | man;
  endfunction

  task automatic model_step();
    bit chg, can, acc;
    chg = (mode_i != m_mode) || arm_i;
    can = (m_st == 0) || (m_st == 2 && m_mode[0] && m_i == 0);
    acc = !chg && can && edge_evt(fall_sel_i, m_s2, m_pv, man_trig_i);
    if (chg || acc || m_st == 1) begin
      m_addr = 0; m_mark = 0;
    end else if (m_st == 2 && chip_en_i) begin
      m_mark = (m_addr >= int'(seq_last_i));
      m_addr = m_mark ? 0 : m_addr + 1;
    end
    if (chg) begin
      m_mode = mode_i; m_st = mode_i[1] ? 0 : 2; m_i = 0; m_d = 0;
    end else if (acc) begin
      if (delay_i == 0) begin m_st = 2; m_i = int'(inhibit_i); end
      else begin m_st = 1; m_d = int'(delay_i); end
    end else if (chip_en_i) begin
      if (m_st == 1) begin
        if (m_d == 1) begin m_st = 2; m_i = int'(inhibit_i); end
        m_d--;
      end else if (m_st == 2 && m_i != 0) m_i--;
    end
    m_trig = acc;
    m_pv = m_s2; m_s2 = m_s1; m_s1 = trig_i;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_st = 2; m_d = 0; m_i = 0; m_addr = 0;
      m_mark = 0; m_trig = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
    end else model_step();
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(int'(addr_o), m_addr, "R1 model addr");
      check(int'(marker_o), int'(m_mark), "R2 model marker");
      check(int'(trig_o), int'(m_trig), "R10 model trig");
      check(int'(run_o), int'(m_st == 2), "R4 model run");
    end
  end

  task automatic tick(input bit en, input bit mt);
    chip_en_i  = en;
    man_trig_i = mt;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1c3d5));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    check(int'(addr_o), 0, "R12 addr");
    check(int'(marker_o), 0, "R12 marker");
    check(int'(trig_o), 0, "R12 trig");
    check(int'(run_o), 1, "R12 run");

    // R1/R2 auto counting through a wrap at last=4
    repeat (5) tick(1, 0);
    check(int'(addr_o), 0, "R1 wrap addr");
    check(int'(marker_o), 1, "R2 marker at wrap");
    repeat (2) tick(1, 0);
    check(int'(addr_o), 2, "R1 addr after wrap");
    check(int'(marker_o), 0, "R2 marker cleared");

    // R3 auto ignores manual strobe
    tick(0, 1);
    check(int'(trig_o), 0, "R3 trig");
    tick(1, 0);
    check(int'(addr_o), 3, "R3 addr continues");

    // R11/R4 mode change to retrigger, then R8 delayed restart
    mode_i = 2'd1;
    tick(0, 0);
    check(int'(addr_o), 0, "R11 addr");
    check(int'(run_o), 1, "R4 running");
    delay_i = CW'(3);
    tick(0, 1);
    check(int'(trig_o), 1, "R10 trig pulse");
    check(int'(run_o), 0, "R8 delaying");
    tick(1, 0);
    check(int'(trig_o), 0, "R10 pulse ends");
    tick(1, 0);
    check(int'(run_o), 0, "R8 still delaying");
    tick(1, 0);
    check(int'(run_o), 1, "R8 run after delay");
    check(int'(addr_o), 0, "R8 addr at start");
    tick(1, 0);
    check(int'(addr_o), 1, "R8 first step");

    // R9 inhibit window of 2 chips
    delay_i = '0; inhibit_i = CW'(2);
    tick(0, 1);
    check(int'(trig_o), 1, "R9 first accepted");
    tick(0, 1);
    check(int'(trig_o), 0, "R9 inhibited");
    tick(1, 0);
    tick(0, 1);
    check(int'(trig_o), 0, "R9 still inhibited");
    tick(1, 0);
    check(int'(addr_o), 2, "R9 addr");
    tick(0, 1);
    check(int'(trig_o), 1, "R9 accepted after window");
    check(int'(addr_o), 0, "R4 restart addr");

    // R5 armed auto
    inhibit_i = '0;
    mode_i = 2'd2;
    tick(0, 0);
    check(int'(run_o), 0, "R5 waiting");
    tick(1, 0);
    check(int'(addr_o), 0, "R5 held");
    tick(0, 1);
    check(int'(trig_o), 1, "R5 first trig");
    check(int'(run_o), 1, "R5 running");
    tick(1, 0);
    tick(0, 1);
    check(int'(trig_o), 0, "R5 later trig ignored");
    tick(1, 0);
    check(int'(addr_o), 2, "R5 addr unaffected");

    // R7/R6 armed retrigger with external edges
    mode_i = 2'd3;
    tick(0, 0);
    check(int'(run_o), 0, "R6 waiting");
    trig_i = 1'b1;
    tick(0, 0); tick(0, 0);
    check(int'(trig_o), 0, "R7 rising latency");
    tick(0, 0);
    check(int'(trig_o), 1, "R7 rising edge");
    check(int'(run_o), 1, "R6 started");
    tick(1, 0);
    tick(0, 1);
    check(int'(trig_o), 1, "R6 retrigger accepted");
    fall_sel_i = 1'b1;
    trig_i = 1'b0;
    tick(0, 0); tick(0, 0);
    check(int'(trig_o), 0, "R7 falling latency");
    tick(0, 0);
    check(int'(trig_o), 1, "R7 falling edge");
    trig_i = 1'b1;
    tick(0, 0); tick(0, 0); tick(0, 0);
    check(int'(trig_o), 0, "R7 rising ignored when falling selected");

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      mode_i     = 2'($urandom_range(0, 3));
      seq_last_i = AW'($urandom_range(0, 12));
      delay_i    = CW'($urandom_range(0, 4));
      inhibit_i  = CW'($urandom_range(0, 6));
      fall_sel_i = 1'($urandom_range(0, 1));
      for (int c = 0; c < 600; c++) begin
        if ($urandom_range(0, 24) == 0) trig_i = ~trig_i;
        arm_i = ($urandom_range(0, 299) == 0);
        tick(($urandom_range(0, 2) != 0) ^ (ph[0] & ($urandom_range(0, 1) == 0)),
             $urandom_range(0, 39) == 0);
      end
      arm_i = 1'b0;
    end
    tick(0, 0);
    finish_run();
  end
endmodule